// File: doc/BRIEF.md
# Eight-Axis Frame-Paced Step Pulse Generator

This block drives eight stepper-motor axes, each with an active-low step line and a direction line. Time is split into fixed-length frames, and each frame is split into 256 equal sub-ticks. At every frame boundary the block raises an interrupt request. The host answers by writing the eight velocity words for the following frame into shadow registers. At the next boundary all eight shadows are copied into the active set at once, so every axis changes speed in the same frame.

Each velocity word holds a direction flag in its top bit and a 12-bit magnitude in its low bits. The magnitude is clipped to 255 and sets how many step pulses the axis produces in the frame. A per-axis 8-bit phase accumulator adds the speed on every sub-tick. Each carry out of the accumulator starts one pulse, which spreads the pulses evenly across the frame. The direction line changes only at a frame boundary. The first pulse of a frame never falls until one full sub-tick later.

Top module: `frame_stepper`

## Requirements
- R1: A frame lasts SUB_CYCLES*256 clock cycles. `irq` is set by the clock edge that ends each frame, so it rises once per frame.
- R2: Once set, `irq` stays high until `irq_ack` is sampled high, and it is low on the following cycle. A frame end in the same cycle as the acknowledge keeps it set.
- R3: Velocity words written during a frame do not change the step output of that frame. All eight axes take their new values at the next frame boundary.
- R4: In each frame an axis produces exactly as many step pulses as its clipped speed, from 0 to 255.
- R5: The magnitude is `wr_data[11:0]`. Any value above 255 is treated as 255. Bits 14:12 have no effect.
- R6: Bit 15 of the velocity word sets direction: 0 drives `dir` high (forward), 1 drives it low (reverse). `dir` changes only at a frame boundary.
- R7: `step_n` rests high. Each step is a low pulse of exactly PULSE_CYCLES clock cycles.
- R8: An axis whose speed is 0 keeps its `step_n` line high for the whole frame.
- R9: After reset, `step_n` and `dir` are all high, `irq` is low, and all speeds are 0.
- R10: For any nonzero speed, the first pulse of a frame falls exactly SUB_CYCLES cycles after the boundary edge. `dir` is therefore held for one sub-tick before any step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe for one velocity word |
| wr_axis | input | $clog2(AXES) | Axis whose shadow register is written |
| wr_data | input | 16 | Velocity word: bit 15 direction, bits 11:0 magnitude |
| irq_ack | input | 1 | Clears the interrupt request |
| irq | output | 1 | Frame interrupt request |
| step_n | output | AXES | Active-low step pulses, one bit per axis |
| dir | output | AXES | Direction, high means forward |

## Verification
Every result is due at a known number of edges after a frame boundary. A new speed and direction are visible in the cycle right after the boundary edge, and the first pulse falls SUB_CYCLES cycles later. `irq` drops one edge after the acknowledge, and the next boundary comes SUB_CYCLES*256 edges after the previous one. The bench finds each boundary by watching `irq` on falling clock edges. It counts cycles from that point to measure frame length, first-pulse delay and pulse width, and it tallies step falls over exactly one frame. Host writes made in the middle of a frame run in parallel with the count, so the bench checks that they are held back until the next boundary.

// File: rtl/frame_stepper.sv
module frame_stepper #(
  parameter int AXES         = 8,
  parameter int VEL_W        = 16,
  parameter int MAG_W        = 12,
  parameter int SPEED_W      = 8,
  parameter int SUB_CYCLES   = 4563,
  parameter int PULSE_CYCLES = 250
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [$clog2(AXES)-1:0] wr_axis,
  input  logic [VEL_W-1:0]        wr_data,
  input  logic                    irq_ack,
  output logic                    irq,
  output logic [AXES-1:0]         step_n,
  output logic [AXES-1:0]         dir
);
  localparam int AX_W  = $clog2(AXES);
  localparam int CYC_W = $clog2(SUB_CYCLES + 1);
  localparam int PW    = $clog2(PULSE_CYCLES + 1);

  logic [CYC_W-1:0]   cyc;
  logic [SPEED_W-1:0] sub;
  logic               tick, frame_end;

  assign tick      = cyc == CYC_W'(SUB_CYCLES - 1);
  assign frame_end = tick && (sub == {SPEED_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= '0;
      sub <= '0;
      irq <= 1'b0;
    end else begin
      cyc <= tick ? '0 : cyc + 1'b1;
      if (tick) sub <= sub + 1'b1;
      if (frame_end)    irq <= 1'b1;
      else if (irq_ack) irq <= 1'b0;
    end
  end

  // R1
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> irq);
  // R2
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !frame_end) |=> !irq);
  // R2
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  for (genvar i = 0; i < AXES; i++) begin : g_axis
    logic [VEL_W-1:0]   shadow;
    logic [SPEED_W-1:0] speed, acc, clipped;
    logic [SPEED_W:0]   sum;
    logic [PW-1:0]      pcnt;
    logic               dir_q;

    assign sum     = {1'b0, acc} + {1'b0, speed};
    assign clipped = (|shadow[MAG_W-1:SPEED_W]) ? {SPEED_W{1'b1}} : shadow[SPEED_W-1:0];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow <= '0;
        speed  <= '0;
        acc    <= '1;
        dir_q  <= 1'b1;
        pcnt   <= '0;
      end else begin
        if (wr_en && wr_axis == AX_W'(i)) shadow <= wr_data;
        if (frame_end) begin
          speed <= clipped;
          dir_q <= ~shadow[VEL_W-1];
          acc   <= '1;
        end else if (tick) begin
          acc <= sum[SPEED_W-1:0];
        end
        if (tick && !frame_end && sum[SPEED_W]) pcnt <= PW'(PULSE_CYCLES);
        else if (pcnt != '0)                    pcnt <= pcnt - 1'b1;
      end
    end

    assign step_n[i] = (pcnt == '0);
    assign dir[i]    = dir_q;

    // R8
    zero_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (speed == '0) |-> step_n[i]);
    // R6
    dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(dir[i]));
    // R10
    no_step_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> step_n[i]);
  end
endmodule

// File: tb/frame_stepper_tb_top.sv
module frame_stepper_tb_top;
  localparam int SUB   = 4;
  localparam int PW    = 2;
  localparam int FRAME = SUB * 256;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, irq_ack = 1'b0;
  logic [2:0]  wr_axis = '0;
  logic [15:0] wr_data = '0;
  wire         irq;
  wire  [7:0]  step_n, dir;

  frame_stepper #(.SUB_CYCLES(SUB), .PULSE_CYCLES(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_axis(wr_axis), .wr_data(wr_data),
    .irq_ack(irq_ack), .irq(irq), .step_n(step_n), .dir(dir));

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  int falls [8];
  int first_fall, frame_len, bad_width;
  logic [7:0] dir_at_start;

  logic [15:0] set_a [8] = '{16'h0000, 16'h0001, 16'h0002, 16'h0003,
                             16'h0064, 16'h00FF, 16'h0080, 16'h0007};
  logic [15:0] set_b [8] = '{16'h8005, 16'h0FFF, 16'h0100, 16'h7123,
                             16'h8000, 16'h80FF, 16'h0011, 16'h00C8};
  logic [15:0] set_z [8] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000,
                             16'h0000, 16'h0000, 16'h0000, 16'h0000};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_speed(input logic [15:0] w);
    return (w[11:0] > 12'd255) ? 255 : int'(w[7:0]);
  endfunction

  task automatic write_set(input logic [15:0] s [8]);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_axis = 3'(i); wr_data = s[i];
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sync_boundary();
    @(negedge clk);
    while (!irq) @(negedge clk);
  endtask

  task automatic count_frame();
    logic [7:0] prev;
    int low_len [8];
    int cyc;
    for (int a = 0; a < 8; a++) begin falls[a] = 0; low_len[a] = 0; end
    first_fall = -1; bad_width = 0; cyc = 0;
    dir_at_start = dir; prev = step_n; irq_ack = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) irq_ack = 1'b0;
      for (int a = 0; a < 8; a++) begin
        if (prev[a] && !step_n[a]) begin
          falls[a]++; low_len[a] = 1;
          if (first_fall < 0 || cyc < first_fall) first_fall = cyc;
        end else if (!step_n[a]) begin
          low_len[a]++;
        end else if (!prev[a]) begin
          if (low_len[a] != PW) bad_width++;
        end
      end
      prev = step_n;
      if (irq && cyc >= 1) break;
    end
    frame_len = cyc;
  endtask

  task automatic test_reset();
    chk(step_n == 8'hFF, "R9 step_n after reset", step_n, 8'hFF);
    chk(dir == 8'hFF, "R9 dir after reset", dir, 8'hFF);
    chk(irq == 1'b0, "R9 irq after reset", irq, 0);
  endtask

  task automatic test_load_and_count();
    write_set(set_a);
    sync_boundary();
    fork
      count_frame();
      begin repeat (300) @(negedge clk); write_set(set_b); end
    join
    for (int a = 0; a < 8; a++) begin
      chk(falls[a] == exp_speed(set_a[a]), "R4/R3 pulses per frame, mid-frame writes held", falls[a], exp_speed(set_a[a]));
      chk(dir_at_start[a] == ~set_a[a][15], "R6 dir forward", dir_at_start[a], ~set_a[a][15]);
    end
    chk(falls[0] == 0, "R8 zero speed no pulses", falls[0], 0);
    chk(frame_len == FRAME, "R1 frame length", frame_len, FRAME);
    chk(first_fall == SUB, "R10 first pulse delay", first_fall, SUB);
    chk(bad_width == 0, "R7 pulse width mismatches", bad_width, 0);
  endtask

  task automatic test_clip_and_dir();
    fork
      count_frame();
      begin repeat (500) @(negedge clk); write_set(set_z); end
    join
    for (int a = 0; a < 8; a++) begin
      chk(falls[a] == exp_speed(set_b[a]), "R5 clipped pulse count", falls[a], exp_speed(set_b[a]));
      chk(dir_at_start[a] == ~set_b[a][15], "R6 dir from bit 15", dir_at_start[a], ~set_b[a][15]);
    end
    chk(falls[4] == 0, "R8 reverse with zero speed", falls[4], 0);
    chk(frame_len == FRAME, "R1 frame length second frame", frame_len, FRAME);
    chk(bad_width == 0, "R7 pulse width at full speed", bad_width, 0);
  endtask

  task automatic test_all_zero();
    count_frame();
    for (int a = 0; a < 8; a++)
      chk(falls[a] == 0, "R8 all axes idle", falls[a], 0);
    chk(step_n == 8'hFF, "R8 step lines high", step_n, 8'hFF);
    chk(dir == 8'hFF, "R6 dir back to forward", dir, 8'hFF);
  endtask

  task automatic test_irq_hold();
    repeat (FRAME + 50) @(negedge clk);
    chk(irq == 1'b1, "R2 irq held without ack", irq, 1);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    chk(irq == 1'b0, "R2 irq cleared by ack", irq, 0);
    repeat (20) @(negedge clk);
    chk(irq == 1'b0, "R2 irq stays clear", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_load_and_count();
    test_clip_and_dir();
    test_all_zero();
    test_irq_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule